// File: doc/BRIEF.md
# Remote Page Table Packet Header Builder

This block sits on the send side of a network interface and turns a single bus access into the header of an outgoing packet. When the processor touches an address inside the device proxy region, the block takes that address as the transfer destination. It splits the address into a page number and a 4 KB page offset. The low bits of the page number select an entry in a remote page table, which software loads beforehand. The entry names the destination node and the physical page on that node.

After one registered table read, the block emits a two-word header on a valid/ready output. The first word carries the node ID. The second word carries the remote physical address, which is the looked-up page joined to the original offset. Payload is only sent in whole 4-byte words, so a request whose offset is not word aligned is refused with an error pulse. A request that selects an invalid table entry is also refused with an error pulse, and no header is emitted. Strobes outside the device region are ignored, and so are strobes that arrive while a request is in progress.

Top module: `rpt_hdr_builder`

## Requirements
- R1: After reset, hdrValid, busy, errAlign and errMiss are all 0.
- R2: A strobe whose address has bits [31:30] = 2'b11, bits [1:0] = 0 and a valid entry produces hdrValid two cycles after the strobe edge. Word 0 (hdrLast = 0) carries the entry's node ID in bits [NODE_W-1:0], with all higher bits zero.
- R3: Word 1 (hdrLast = 1) equals {entry page, address bits [11:0]}.
- R4: The entry index is address bits [12+IDX_W-1:12]. Page-number bits above the index have no effect on the header.
- R5: Word 1 is presented only after word 0 has been accepted (hdrValid and hdrReady both high at an edge). While hdrReady is low, hdrValid, hdrWord and hdrLast hold steady.
- R6: A device-region strobe with address bits [1:0] != 0 pulses errAlign for one cycle, starting one cycle after the strobe edge. No header follows, and the block stays idle.
- R7: A request whose entry has its valid bit clear pulses errMiss for one cycle, starting two cycles after the strobe edge. No header follows. Entries that were never written are invalid after reset.
- R8: A strobe whose address bits [31:30] != 2'b11 is ignored: busy stays 0 and no header or error follows.
- R9: A strobe that arrives while busy is 1 is ignored. The header in progress is unchanged.
- R10: A table write to the entry being looked up, in the same cycle as the strobe, does not affect that lookup, which returns the old contents. The next request sees the new contents.
- R11: busy is 1 from the cycle after an accepted strobe until word 1 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| proxyValid | input | 1 | Bus access strobe |
| proxyAddr | input | ADDR_W | Physical address of the access |
| tblWrEn | input | 1 | Table write enable |
| tblWrIdx | input | IDX_W | Table entry to write |
| tblWrValid | input | 1 | Valid bit to store |
| tblWrNode | input | NODE_W | Destination node ID to store |
| tblWrPage | input | PAGE_W | Remote physical page to store |
| hdrValid | output | 1 | Header word valid |
| hdrReady | input | 1 | Downstream accepts header word |
| hdrWord | output | PAGE_W+12 | Header word |
| hdrLast | output | 1 | Marks the second (final) header word |
| busy | output | 1 | Request in progress |
| errAlign | output | 1 | One-cycle pulse on a misaligned request |
| errMiss | output | 1 | One-cycle pulse on an invalid table entry |

## Verification
The assertions assume that hdrReady is meaningful only while hdrValid is high. They also assume that proxyValid is a single-cycle pulse per bus access, so that holding the strobe never counts as a new request. The bench keeps to both: it drives each strobe for exactly one cycle, and it changes hdrReady only at falling edges. Table writes in the bench either come before any request or, in the one collision case, land in the same cycle as the strobe to the entry being written.

// File: rtl/rpt_hdr_pkg.sv
package rpt_hdr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_WORD0  = 2'd2,
    ST_WORD1  = 2'd3
  } hdrState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;    // accept request: latch offset, read table
    logic load;       // latch looked-up entry
    logic second;     // present word 1
    logic raiseAlign; // misaligned request
    logic raiseMiss;  // invalid entry
  } hdrCtrl_t;
endpackage

// File: rtl/rpt_table.sv
module rpt_table #(
  parameter int IDX_W  = 6,
  parameter int NODE_W = 8,
  parameter int PAGE_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              wrValid,
  input  logic [NODE_W-1:0] wrNode,
  input  logic [PAGE_W-1:0] wrPage,
  input  logic              rdEn,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic              rdValid,
  output logic [NODE_W-1:0] rdNode,
  output logic [PAGE_W-1:0] rdPage
);
  localparam int DEPTH = 1 << IDX_W;

  logic [NODE_W-1:0] nodeMem [DEPTH];
  logic [PAGE_W-1:0] pageMem [DEPTH];
  logic [DEPTH-1:0]  validMem;

  always_ff @(posedge clk) begin
    if (wrEn) begin
      nodeMem[wrIdx] <= wrNode;
      pageMem[wrIdx] <= wrPage;
    end
    if (rdEn) begin
      rdNode <= nodeMem[rdIdx];
      rdPage <= pageMem[rdIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validMem <= '0;
      rdValid  <= 1'b0;
    end else begin
      if (wrEn) validMem[wrIdx] <= wrValid;
      if (rdEn) rdValid <= validMem[rdIdx];
    end
  end
endmodule

// File: rtl/rpt_hdr_datapath.sv
module rpt_hdr_datapath
  import rpt_hdr_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int REGION_W = 2,
  parameter logic [REGION_W-1:0] DEV_TAG = 2'b11,
  parameter int OFFSET_W = 12,
  parameter int IDX_W    = 6,
  parameter int NODE_W   = 8,
  parameter int PAGE_W   = 20,
  localparam int PN_W    = ADDR_W - REGION_W - OFFSET_W,
  localparam int HDR_W   = PAGE_W + OFFSET_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] proxyAddr,
  input  hdrCtrl_t          ctrl,
  input  logic              rdValid,
  input  logic [NODE_W-1:0] rdNode,
  input  logic [PAGE_W-1:0] rdPage,
  output logic              devHit,
  output logic              aligned,
  output logic [IDX_W-1:0]  rdIdx,
  output logic [HDR_W-1:0]  hdrWord,
  output logic              errAlign,
  output logic              errMiss
);
  logic [OFFSET_W-1:0] offsetQ;
  logic [NODE_W-1:0]   nodeQ;
  logic [PAGE_W-1:0]   pageQ;

  assign devHit  = proxyAddr[ADDR_W-1 -: REGION_W] == DEV_TAG;
  assign aligned = proxyAddr[1:0] == 2'b00;
  assign rdIdx   = proxyAddr[OFFSET_W +: IDX_W];

  generate
    if (IDX_W < PN_W) begin : g_pageHi
      logic unusedPageHi;
      assign unusedPageHi = ^proxyAddr[OFFSET_W+IDX_W +: PN_W-IDX_W];
    end
  endgenerate

  // rdValid is consumed by control; kept here for the lookup bundle
  logic unusedRdValid;
  assign unusedRdValid = rdValid;

  always_ff @(posedge clk) begin
    if (ctrl.capture) offsetQ <= proxyAddr[OFFSET_W-1:0];
    if (ctrl.load) begin
      nodeQ <= rdNode;
      pageQ <= rdPage;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errAlign <= 1'b0;
      errMiss  <= 1'b0;
    end else begin
      errAlign <= ctrl.raiseAlign;
      errMiss  <= ctrl.raiseMiss;
    end
  end

  assign hdrWord = ctrl.second ? {pageQ, offsetQ}
                               : {{(HDR_W-NODE_W){1'b0}}, nodeQ};
endmodule

// File: rtl/rpt_hdr_ctrl.sv
module rpt_hdr_ctrl
  import rpt_hdr_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     proxyValid,
  input  logic     devHit,
  input  logic     aligned,
  input  logic     entryValid,
  input  logic     hdrReady,
  output hdrCtrl_t ctrl,
  output logic     hdrValid,
  output logic     hdrLast,
  output logic     busy
);
  hdrState_e state, stateNext;
  logic idle, hit;

  assign idle = state == ST_IDLE;
  assign hit  = idle && proxyValid && devHit;

  always_comb begin
    ctrl.capture    = hit && aligned;
    ctrl.raiseAlign = hit && !aligned;
    ctrl.load       = (state == ST_LOOKUP) && entryValid;
    ctrl.raiseMiss  = (state == ST_LOOKUP) && !entryValid;
    ctrl.second     = state == ST_WORD1;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (ctrl.capture) stateNext = ST_LOOKUP;
      ST_LOOKUP: stateNext = entryValid ? ST_WORD0 : ST_IDLE;
      ST_WORD0:  if (hdrReady) stateNext = ST_WORD1;
      ST_WORD1:  if (hdrReady) stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign hdrValid = (state == ST_WORD0) || (state == ST_WORD1);
  assign hdrLast  = state == ST_WORD1;
  assign busy     = !idle;
endmodule

// File: rtl/rpt_hdr_builder.sv
module rpt_hdr_builder
  import rpt_hdr_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int REGION_W = 2,
  parameter logic [REGION_W-1:0] DEV_TAG = 2'b11,
  parameter int IDX_W    = 6,
  parameter int NODE_W   = 8,
  parameter int PAGE_W   = 20,
  localparam int OFFSET_W = 12,
  localparam int HDR_W    = PAGE_W + OFFSET_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              proxyValid,
  input  logic [ADDR_W-1:0] proxyAddr,
  input  logic              tblWrEn,
  input  logic [IDX_W-1:0]  tblWrIdx,
  input  logic              tblWrValid,
  input  logic [NODE_W-1:0] tblWrNode,
  input  logic [PAGE_W-1:0] tblWrPage,
  output logic              hdrValid,
  input  logic              hdrReady,
  output logic [HDR_W-1:0]  hdrWord,
  output logic              hdrLast,
  output logic              busy,
  output logic              errAlign,
  output logic              errMiss
);
  hdrCtrl_t          ctrl;
  logic              devHit, aligned, rdValid;
  logic [IDX_W-1:0]  rdIdx;
  logic [NODE_W-1:0] rdNode;
  logic [PAGE_W-1:0] rdPage;

  rpt_table #(.IDX_W(IDX_W), .NODE_W(NODE_W), .PAGE_W(PAGE_W)) uTable (
    .clk(clk), .rstN(rstN),
    .wrEn(tblWrEn), .wrIdx(tblWrIdx), .wrValid(tblWrValid),
    .wrNode(tblWrNode), .wrPage(tblWrPage),
    .rdEn(ctrl.capture), .rdIdx(rdIdx),
    .rdValid(rdValid), .rdNode(rdNode), .rdPage(rdPage)
  );

  rpt_hdr_datapath #(
    .ADDR_W(ADDR_W), .REGION_W(REGION_W), .DEV_TAG(DEV_TAG),
    .OFFSET_W(OFFSET_W), .IDX_W(IDX_W), .NODE_W(NODE_W), .PAGE_W(PAGE_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .proxyAddr(proxyAddr), .ctrl(ctrl),
    .rdValid(rdValid), .rdNode(rdNode), .rdPage(rdPage),
    .devHit(devHit), .aligned(aligned), .rdIdx(rdIdx),
    .hdrWord(hdrWord), .errAlign(errAlign), .errMiss(errMiss)
  );

  rpt_hdr_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .proxyValid(proxyValid),
    .devHit(devHit), .aligned(aligned), .entryValid(rdValid),
    .hdrReady(hdrReady), .ctrl(ctrl),
    .hdrValid(hdrValid), .hdrLast(hdrLast), .busy(busy)
  );
endmodule

// File: rtl/rpt_hdr_checker.sv
module rpt_hdr_checker #(
  parameter int HDR_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             hdrValid,
  input logic             hdrReady,
  input logic [HDR_W-1:0] hdrWord,
  input logic             hdrLast,
  input logic             busy,
  input logic             errAlign,
  input logic             errMiss
);
  AST_HDR_START_AFTER_LOOKUP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hdrValid) |-> $past(busy) && !hdrLast); // R2

  AST_WORD1_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hdrLast) |-> $past(hdrValid && hdrReady)); // R5

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid && !hdrReady |=> hdrValid && $stable(hdrWord) && $stable(hdrLast)); // R5

  AST_ALIGN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    errAlign |-> !busy && !hdrValid); // R6

  AST_MISS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    errMiss |-> !busy && !hdrValid); // R7

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    errMiss |=> !errMiss); // R7

  AST_HDR_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid |-> busy); // R11
endmodule

bind rpt_hdr_builder rpt_hdr_checker #(.HDR_W(HDR_W)) uChk (.*);

// File: tb/tb_rpt_hdr_builder.sv
module tb_rpt_hdr_builder;
  localparam int ADDR_W = 32, IDX_W = 6, NODE_W = 8, PAGE_W = 20, HDR_W = 32;
  localparam int NVEC = 10;
  // {addr, word0, word1, kind}: kind 0 header, 1 align error, 2 miss, 3 ignored
  localparam logic [97:0] VECS [NVEC] = '{
    {32'hC000_1004, 32'h0000_0005, 32'hABCD_E004, 2'd0}, // R2 R3
    {32'hC000_2FFC, 32'h0000_00FF, 32'h0000_1FFC, 2'd0}, // R2 R3
    {32'hC004_1000, 32'h0000_0005, 32'hABCD_E000, 2'd0}, // R4 upper page bits
    {32'hC003_F800, 32'h0000_003C, 32'hFFFF_F800, 2'd0}, // R4 top index
    {32'hC000_1002, 32'h0,         32'h0,         2'd1}, // R6
    {32'hC000_1001, 32'h0,         32'h0,         2'd1}, // R6
    {32'hC000_3000, 32'h0,         32'h0,         2'd2}, // R7 cleared entry
    {32'hC000_A000, 32'h0,         32'h0,         2'd2}, // R7 never written
    {32'h4000_1000, 32'h0,         32'h0,         2'd3}, // R8
    {32'h8000_1004, 32'h0,         32'h0,         2'd3}  // R8
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic proxyValid = 1'b0;
  logic [ADDR_W-1:0] proxyAddr = '0;
  logic tblWrEn = 1'b0, tblWrValid = 1'b0;
  logic [IDX_W-1:0] tblWrIdx = '0;
  logic [NODE_W-1:0] tblWrNode = '0;
  logic [PAGE_W-1:0] tblWrPage = '0;
  logic hdrValid, hdrReady = 1'b1, hdrLast, busy, errAlign, errMiss;
  logic [HDR_W-1:0] hdrWord;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rpt_hdr_builder dut (
    .clk(clk), .rstN(rstN), .proxyValid(proxyValid), .proxyAddr(proxyAddr),
    .tblWrEn(tblWrEn), .tblWrIdx(tblWrIdx), .tblWrValid(tblWrValid),
    .tblWrNode(tblWrNode), .tblWrPage(tblWrPage),
    .hdrValid(hdrValid), .hdrReady(hdrReady), .hdrWord(hdrWord),
    .hdrLast(hdrLast), .busy(busy), .errAlign(errAlign), .errMiss(errMiss)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tblWrite(input int idx, input bit v, input logic [7:0] node, input logic [19:0] page);
    @(negedge clk);
    tblWrEn = 1'b1; tblWrIdx = IDX_W'(idx); tblWrValid = v;
    tblWrNode = node; tblWrPage = page;
    @(negedge clk);
    tblWrEn = 1'b0;
  endtask

  // Leaves time at the first falling edge after the strobe edge
  task automatic strobe(input logic [31:0] addr);
    @(negedge clk);
    proxyValid = 1'b1; proxyAddr = addr;
    @(negedge clk);
    proxyValid = 1'b0;
  endtask

  task automatic expectHeader(input string req, input logic [31:0] w0, input logic [31:0] w1);
    chk("R11 busy after strobe", {31'b0, busy}, 32'd1);
    @(negedge clk);
    chk({req, " word0 valid"}, {30'b0, hdrValid, hdrLast}, 32'b10);
    chk({req, " word0"}, hdrWord, w0);
    @(negedge clk);
    chk({req, " word1 valid"}, {30'b0, hdrValid, hdrLast}, 32'b11);
    chk({req, " word1"}, hdrWord, w1);
    @(negedge clk);
    chk("R11 idle after word1", {30'b0, busy, hdrValid}, 32'b0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {28'b0, hdrValid, busy, errAlign, errMiss}, 32'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", {28'b0, hdrValid, busy, errAlign, errMiss}, 32'b0);

    tblWrite(1, 1'b1, 8'h05, 20'hABCDE);
    tblWrite(2, 1'b1, 8'hFF, 20'h00001);
    tblWrite(3, 1'b1, 8'h11, 20'h22222);
    tblWrite(3, 1'b0, 8'h11, 20'h22222);
    tblWrite(63, 1'b1, 8'h3C, 20'hFFFFF);

    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] a, w0, w1;
      logic [1:0] kind;
      {a, w0, w1, kind} = VECS[i];
      strobe(a);
      case (kind)
        2'd0: expectHeader("R2 R3 R4 vector", w0, w1);
        2'd1: begin
          chk("R6 errAlign pulse", {30'b0, errAlign, busy}, 32'b10);
          @(negedge clk);
          chk("R6 no header", {29'b0, hdrValid, errAlign, busy}, 32'b0);
        end
        2'd2: begin
          chk("R7 lookup busy", {30'b0, busy, errAlign}, 32'b10);
          @(negedge clk);
          chk("R7 errMiss pulse", {30'b0, errMiss, hdrValid}, 32'b10);
          @(negedge clk);
          chk("R7 no header", {29'b0, hdrValid, busy, errMiss}, 32'b0);
        end
        default: begin
          chk("R8 ignored strobe", {30'b0, busy, errAlign}, 32'b0);
          @(negedge clk);
          chk("R8 nothing follows", {30'b0, hdrValid, errMiss}, 32'b0);
        end
      endcase
    end

    // R5 stall and R9 strobe while busy
    hdrReady = 1'b0;
    strobe(32'hC000_1004);
    @(negedge clk);
    chk("R5 word0 presented", hdrWord, 32'h0000_0005);
    for (int k = 0; k < 3; k++) begin
      if (k == 1) begin proxyValid = 1'b1; proxyAddr = 32'hC000_2008; end
      @(negedge clk);
      proxyValid = 1'b0;
      chk("R5 word0 held in stall", {hdrWord[29:0], hdrValid, hdrLast}, {30'h0000_0005, 2'b10});
    end
    hdrReady = 1'b1;
    @(negedge clk);
    chk("R5 R9 word1 after accept", hdrWord, 32'hABCD_E004);
    chk("R5 last flag", {31'b0, hdrLast}, 32'd1);
    @(negedge clk);
    chk("R9 no second request", {30'b0, busy, hdrValid}, 32'b0);
    @(negedge clk);
    chk("R9 still idle", {30'b0, busy, hdrValid}, 32'b0);

    // R10 same-cycle write to the looked-up entry
    @(negedge clk);
    proxyValid = 1'b1; proxyAddr = 32'hC000_2010;
    tblWrEn = 1'b1; tblWrIdx = 6'd2; tblWrValid = 1'b1;
    tblWrNode = 8'h77; tblWrPage = 20'h12345;
    @(negedge clk);
    proxyValid = 1'b0; tblWrEn = 1'b0;
    expectHeader("R10 old contents", 32'h0000_00FF, 32'h0000_1010);
    strobe(32'hC000_2010);
    expectHeader("R10 new contents", 32'h0000_0077, 32'h1234_5010);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule